// File: doc/BRIEF.md
# Pin Wakeup Pattern Detector

This block watches a single pad, chosen at run time from a vector of pad inputs, and raises a wakeup request when that pad shows a programmed pattern. Everything runs on the always-on clock, so the selected pad is sampled into a register before anything else looks at it. An optional debounce stage passes a new level only after it has been seen on several samples in a row.

The detector looks for one of five patterns. Three are edges: rising, falling or either. Two are pulses, high or low, whose length is measured by an 8-bit run-length counter and compared with a programmed threshold. On a match, a sticky cause flag is set and the wakeup request is raised. Both stay up until software clears them. The run-length counter is deliberately not cleared when the mode is changed while the detector is enabled. Software that wants a clean measurement disables the detector before it changes the mode.

Top module: `pin_wake_detector`

## Requirements
- R1: `pad_sel` picks which bit of `pad_in` is observed. Activity on any other pad has no effect on `cause`.
- R2: Mode 0 detects a rising edge, mode 1 a falling edge and mode 2 either edge. With the filter off, a pad level driven before rising clock edge E0 is reflected in `cause` after edge E2 and not before.
- R3: With `filt_en` = 1, a new level is passed on only once it has been sampled on 4 consecutive clock edges. A level that lasts 3 cycles or fewer is ignored. A level that lasts 4 or more cycles keeps its width and appears 4 cycles later than with the filter off.
- R4: Mode 3 (high pulse) fires on a high-to-low transition of the filtered level when the high phase lasted at least `pulse_thresh` cycles. Mode 4 (low pulse) fires on a low-to-high transition when the low phase lasted at least `pulse_thresh` cycles.
- R5: The run-length counter saturates at 255, so any pulse of 255 or more cycles meets a threshold of 255.
- R6: While the detector stays enabled, a change of `det_mode` does not restart the run-length counter. A phase that started under one mode is measured in full under the next.
- R7: While `det_en` is 0, no new cause is set and the run-length counter is held at 0. A phase that spans a disable is measured only from the re-enable.
- R8: Mode values 5, 6 and 7 never detect anything.
- R9: `cause` is sticky after a match, and `wake_req` always equals `cause`.
- R10: A `cause_clr` pulse clears both `cause` and `wake_req` on the next clock edge. The clear takes priority over a match in the same cycle.
- R11: After reset, `cause` and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NumPads | Raw pad input levels |
| pad_sel | input | SelW | Index of the observed pad |
| det_en | input | 1 | Detector enable |
| det_mode | input | 3 | Pattern select (0 rise, 1 fall, 2 either, 3 high pulse, 4 low pulse) |
| filt_en | input | 1 | Debounce filter enable |
| pulse_thresh | input | CntW | Minimum pulse length in cycles |
| cause_clr | input | 1 | Clears the sticky cause |
| wake_req | output | 1 | Wakeup request |
| cause | output | 1 | Sticky match flag |

## Verification
A corrupted history in the debounce stage appears as a missing or early match, off by whole cycles, on the second edge after the filtered level should have changed. A wrong run-length count cannot be seen until the end of a pulse, when a pulse near the threshold fires or fails to fire. For this reason, the stimulus places pulses exactly at the threshold and one cycle below it. A counter that restarts on a mode change or survives a disable shows up only in a scenario that spans that event, and the directed tests build exactly those scenarios.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [2:0] {
    MODE_RISE       = 3'd0,
    MODE_FALL       = 3'd1,
    MODE_EDGE       = 3'd2,
    MODE_HIGH_PULSE = 3'd3,
    MODE_LOW_PULSE  = 3'd4
  } pwd_mode_e;
endpackage

// File: rtl/pwd_pad_sample.sv
module pwd_pad_sample #(
  parameter int NumPads = 8,
  localparam int SelW = (NumPads > 1) ? $clog2(NumPads) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NumPads-1:0] pad_in,
  input  logic [SelW-1:0]    pad_sel,
  output logic               smp
);
  localparam logic [SelW:0] PadCount = NumPads[SelW:0];

  logic picked;
  always_comb begin
    picked = 1'b0;
    if ({1'b0, pad_sel} < PadCount) picked = pad_in[pad_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) smp <= 1'b0;
    else     smp <= picked;
  end
endmodule

// File: rtl/pwd_debounce.sv
module pwd_debounce #(
  parameter int StableLen = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic filt_en,
  input  logic smp,
  output logic lvl
);
  logic [StableLen-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      lvl  <= 1'b0;
    end else begin
      hist <= {hist[StableLen-2:0], smp};
      if (!filt_en)         lvl <= smp;
      else if (&hist)       lvl <= 1'b1;
      else if (~|hist)      lvl <= 1'b0;
    end
  end

  // R3: a filtered change agrees with the sample taken two edges earlier
  p_filt_agree_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_en) && (lvl != $past(lvl))) |-> (lvl == $past(smp, 2)));
endmodule

// File: rtl/pwd_pattern.sv
module pwd_pattern
  import pwd_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [2:0]      mode,
  input  logic [CntW-1:0] thresh,
  input  logic            lvl,
  output logic            hit
);
  localparam logic [CntW-1:0] CntMax = '1;

  logic            prev;
  logic [CntW-1:0] run_cnt;
  logic            long_enough;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  // run length of the current level, independent of mode
  always_ff @(posedge clk) begin
    if (rst || !en)           run_cnt <= '0;
    else if (lvl != prev)     run_cnt <= {{(CntW-1){1'b0}}, 1'b1};
    else if (run_cnt != CntMax) run_cnt <= run_cnt + 1'b1;
  end

  assign long_enough = (run_cnt >= thresh);

  always_comb begin
    hit = 1'b0;
    if (en) begin
      case (pwd_mode_e'(mode))
        MODE_RISE:       hit = lvl & ~prev;
        MODE_FALL:       hit = ~lvl & prev;
        MODE_EDGE:       hit = lvl ^ prev;
        MODE_HIGH_PULSE: hit = prev & ~lvl & long_enough;
        MODE_LOW_PULSE:  hit = ~prev & lvl & long_enough;
        default:         hit = 1'b0;
      endcase
    end
  end

  // R5: once saturated, a steady level keeps the counter at its ceiling
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && en && $past(lvl == prev) && $past(run_cnt) == CntMax) |-> (run_cnt == CntMax));
  // R6: a steady level keeps counting across any mode value
  p_cnt_mode_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(lvl == prev) && $past(run_cnt) != CntMax && $past(mode) != mode)
      |-> (run_cnt == $past(run_cnt) + 1'b1));
  // R7: a disabled detector reports nothing
  p_quiet_off_r7: assert property (@(posedge clk) disable iff (rst) !en |-> !hit);
  // R8: reserved modes never match
  p_reserved_r8: assert property (@(posedge clk) disable iff (rst) (mode > 3'd4) |-> !hit);
endmodule

// File: rtl/pin_wake_detector.sv
module pin_wake_detector #(
  parameter int NumPads   = 8,
  parameter int CntW      = 8,
  parameter int StableLen = 4,
  localparam int SelW = (NumPads > 1) ? $clog2(NumPads) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NumPads-1:0] pad_in,
  input  logic [SelW-1:0]    pad_sel,
  input  logic               det_en,
  input  logic [2:0]         det_mode,
  input  logic               filt_en,
  input  logic [CntW-1:0]    pulse_thresh,
  input  logic               cause_clr,
  output logic               wake_req,
  output logic               cause
);
  logic smp, lvl, hit, cause_q;

  pwd_pad_sample #(.NumPads(NumPads)) u_sample (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pad_sel(pad_sel), .smp(smp)
  );

  pwd_debounce #(.StableLen(StableLen)) u_filter (
    .clk(clk), .rst(rst), .filt_en(filt_en), .smp(smp), .lvl(lvl)
  );

  pwd_pattern #(.CntW(CntW)) u_match (
    .clk(clk), .rst(rst), .en(det_en), .mode(det_mode), .thresh(pulse_thresh),
    .lvl(lvl), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst || cause_clr) cause_q <= 1'b0;
    else if (hit)         cause_q <= 1'b1;
  end

  assign cause    = cause_q;
  assign wake_req = cause_q;

  // R9: a set cause holds until cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (cause && !cause_clr) |=> cause);
  // R10: a clear always lands on the next edge
  p_clear_r10: assert property (@(posedge clk) disable iff (rst) cause_clr |=> !cause);
  // R7: no cause appears while disabled
  p_no_set_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!det_en && !cause) |=> !cause);
endmodule

// File: tb/sim_pin_wake_detector.sv
module sim_pin_wake_detector;
  localparam int ClkPeriod = 10;
  localparam int NP = 8;
  localparam int SEL = 3;

  typedef struct packed {
    logic [2:0] mode;
    logic       filt;
    logic       start;
    logic [8:0] width;
    logic [7:0] thr;
    logic       exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 1'b0, 9'd1,   8'd0,   1'b1},
    '{3'd1, 1'b0, 1'b0, 9'd2,   8'd0,   1'b1},
    '{3'd2, 1'b0, 1'b1, 9'd1,   8'd0,   1'b1},
    '{3'd0, 1'b1, 1'b0, 9'd3,   8'd0,   1'b0},
    '{3'd0, 1'b1, 1'b0, 9'd4,   8'd0,   1'b1},
    '{3'd3, 1'b0, 1'b0, 9'd10,  8'd10,  1'b1},
    '{3'd3, 1'b0, 1'b0, 9'd9,   8'd10,  1'b0},
    '{3'd4, 1'b0, 1'b1, 9'd5,   8'd5,   1'b1},
    '{3'd4, 1'b1, 1'b1, 9'd6,   8'd7,   1'b0},
    '{3'd3, 1'b1, 1'b0, 9'd8,   8'd8,   1'b1},
    '{3'd5, 1'b0, 1'b0, 9'd3,   8'd0,   1'b0},
    '{3'd7, 1'b0, 1'b1, 9'd3,   8'd0,   1'b0},
    '{3'd3, 1'b0, 1'b0, 9'd300, 8'd255, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pad_in = '0;
  logic [2:0] pad_sel = 3'(SEL);
  logic det_en = 1'b0;
  logic [2:0] det_mode = 3'd0;
  logic filt_en = 1'b0;
  logic [7:0] pulse_thresh = 8'd0;
  logic cause_clr = 1'b0;
  logic wake_req, cause;

  int n_chk = 0;
  int n_fail = 0;

  always #(ClkPeriod/2) clk = ~clk;

  pin_wake_detector #(.NumPads(NP)) u0 (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pad_sel(pad_sel), .det_en(det_en),
    .det_mode(det_mode), .filt_en(filt_en), .pulse_thresh(pulse_thresh),
    .cause_clr(cause_clr), .wake_req(wake_req), .cause(cause)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    det_en = 1'b0; cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.mode > 3'd4)        return "R8";
    else if (v.width > 9'd255) return "R5";
    else if (v.filt)          return "R3";
    else if (v.mode >= 3'd3)  return "R4";
    else                      return "R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R11 cause after reset", cause, 1'b0);
    chk("R11 wake_req after reset", wake_req, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      clear_all();
      pad_sel = 3'(SEL);
      pad_in[SEL] = VECS[i].start;
      tick(10);
      det_mode = VECS[i].mode; filt_en = VECS[i].filt; pulse_thresh = VECS[i].thr;
      det_en = 1'b1;
      tick(3);
      pad_in[SEL] = ~VECS[i].start;
      tick(int'(VECS[i].width));
      pad_in[SEL] = VECS[i].start;
      tick(12);
      chk(tag_of(VECS[i]), cause, VECS[i].exp);
      chk("R9 wake_req mirrors cause", wake_req, VECS[i].exp);
    end

    // R2 latency, unfiltered rise
    clear_all(); pad_in = '0; filt_en = 1'b0; det_mode = 3'd0; tick(8);
    det_en = 1'b1; tick(2);
    pad_in[SEL] = 1'b1; tick(2);
    chk("R2 not yet at edge 2", cause, 1'b0);
    tick(1);
    chk("R2 set after edge 3", cause, 1'b1);

    // R9 sticky, R10 clear
    pad_in[SEL] = 1'b0; tick(20);
    chk("R9 cause still set", cause, 1'b1);
    cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
    chk("R10 cause cleared", cause, 1'b0);
    chk("R10 wake_req cleared", wake_req, 1'b0);

    // R3 latency, filtered rise
    clear_all(); pad_in = '0; filt_en = 1'b1; det_mode = 3'd0; tick(8);
    det_en = 1'b1; tick(2);
    pad_in[SEL] = 1'b1; tick(6);
    chk("R3 not yet at edge 6", cause, 1'b0);
    tick(1);
    chk("R3 set after edge 7", cause, 1'b1);

    // R1 other pads ignored, selected pad seen
    clear_all(); pad_in = '0; filt_en = 1'b0; det_mode = 3'd2; pad_sel = 3'd7; tick(8);
    det_en = 1'b1; tick(2);
    pad_in[2] = 1'b1; tick(3); pad_in[2] = 1'b0; tick(3); pad_in[0] = 1'b1; tick(5);
    chk("R1 unselected pads ignored", cause, 1'b0);
    pad_in[7] = 1'b1; tick(5);
    chk("R1 selected pad 7 detected", cause, 1'b1);

    // R6 mode change keeps the run length
    clear_all(); pad_in = '0; pad_sel = 3'(SEL); det_mode = 3'd0; tick(8);
    det_en = 1'b1; tick(2);
    pad_in[SEL] = 1'b1; tick(4);
    cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
    chk("R6 cleared before mode change", cause, 1'b0);
    det_mode = 3'd3; pulse_thresh = 8'd10; tick(7);
    pad_in[SEL] = 1'b0; tick(6);
    chk("R6 pulse spans mode change", cause, 1'b1);

    // R7 disable restarts the count and blocks causes
    clear_all(); pad_in = '0; det_mode = 3'd3; pulse_thresh = 8'd10; tick(8);
    det_en = 1'b1; tick(2);
    pad_in[SEL] = 1'b1; tick(8);
    det_en = 1'b0; tick(1); det_en = 1'b1; tick(4);
    pad_in[SEL] = 1'b0; tick(6);
    chk("R7 count restarted by disable", cause, 1'b0);
    det_en = 1'b0; det_mode = 3'd2;
    pad_in[SEL] = 1'b1; tick(4); pad_in[SEL] = 1'b0; tick(6);
    chk("R7 no cause while disabled", cause, 1'b0);

    // R10 clear wins over a simultaneous match
    clear_all(); pad_in = '0; det_mode = 3'd0; tick(8);
    det_en = 1'b1; tick(2);
    pad_in[SEL] = 1'b1; tick(2);
    cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
    chk("R10 clear beats match", cause, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule